// File: doc/BRIEF.md
# Serially Loaded Output Pin Bank

This block lets an external controller set a bank of general-purpose output pins over a four-wire serial link. The controller acts as link master and the block is the slave. The pin values are the bits shifted in, taken as they are, with no command layer. Every register runs on one free-running system clock. The serial clock, select and data-in lines are resynchronized and treated as sampled data, never as clocks. The system clock therefore has to run several times faster than the serial clock. Eight system clocks per serial half-period is a comfortable margin.

A transfer begins when select goes low. At that point the shift register is preloaded with the present pin state, so the master reads that state back on the data-out line while it clocks the new word in. The link uses clock polarity 0 and phase 0, with the most significant bit first. A bit is captured on each rising serial-clock edge, and data-out moves on each falling edge. When select goes high again, the gathered word is copied to the pins, but only if exactly as many bits arrived as there are pins. Any other bit count leaves the pins as they were.

Top module: `spi_pin_expander`

## Requirements
- R1: A synchronous active-high reset drives all pins to 0, and holds `spi_miso` and `spi_miso_oe` at 0.
- R2: After select is released following exactly WIDTH rising serial-clock edges, the pins equal the received word, with the first bit received on the most significant pin.
- R3: The pins do not change while select is active.
- R4: If select is released after fewer than WIDTH bits, the transfer is discarded and the pins keep their value.
- R5: If select is released after more than WIDTH bits, the transfer is discarded and the pins keep their value.
- R6: During a transfer, `spi_miso` first presents the pin state from before the transfer, most significant bit first. After WIDTH bits, it continues with the bits received in this transfer, in the order they arrived.
- R7: While select is inactive, `spi_miso` and `spi_miso_oe` are 0. While select is active, `spi_miso_oe` is 1.
- R8: Serial-clock activity while select is inactive has no effect: the pins keep their value, and the next transfer behaves normally.
- R9: `spi_miso` changes only after a falling serial-clock edge or the activation of select. A rising edge leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run several times faster than the serial clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_sclk | input | 1 | Serial clock from the master (idle low) |
| spi_cs_n | input | 1 | Select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, 0 when not selected |
| spi_miso_oe | output | 1 | High while `spi_miso` should be driven onto a shared line |
| pins | output | WIDTH | Output pin bank |

## Verification
The main function is exercised with a series of full-length words. They include alternating patterns, all ones, all zeros, and words whose two end bits are both 1. Each word is checked both on the pins and on the read-back stream. These words tell apart bit-order errors, stuck bits and off-by-one capture. Transfers one bit short and one bit long are mixed into the same series to show that only an exact count loads the pins. The long transfer also shows that read-back continues with the bits received in that transfer. Serial-clock pulses sent while the block is not selected, and a reset in the middle of the run, confirm that stray activity is ignored and that reset wins.

// File: rtl/spx_pkg.sv
package spx_pkg;
    // Edge/level view of one resynchronized serial input.
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } spx_edge_t;
endpackage

// File: rtl/spx_sync_edge.sv
module spx_sync_edge #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    output spx_pkg::spx_edge_t ev
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], din};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.chain <= {STAGES{IDLE}};
            st_q.prev  <= IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ev.level = st_q.chain[STAGES-1];
    assign ev.rise  = st_q.chain[STAGES-1] & ~st_q.prev;
    assign ev.fall  = ~st_q.chain[STAGES-1] & st_q.prev;
endmodule

// File: rtl/spx_shifter.sv
module spx_shifter #(
    parameter int WIDTH = 8,
    parameter int CW    = $clog2(WIDTH + 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  spx_pkg::spx_edge_t sclk_ev,
    input  spx_pkg::spx_edge_t cs_ev,
    input  logic               mosi_bit,
    input  logic [WIDTH-1:0]   load_val,
    output logic [WIDTH-1:0]   word,
    output logic [CW-1:0]      count,
    output logic               miso_bit
);
    localparam logic [CW-1:0] CNT_SAT = CW'(WIDTH + 1);

    typedef struct packed {
        logic [WIDTH-1:0] shreg;
        logic [CW-1:0]    cnt;
        logic             miso;
    } st_t;

    st_t  st_d, st_q;
    logic cs_active;
    logic cs_start;

    assign cs_active = ~cs_ev.level;
    assign cs_start  = cs_ev.fall;

    always_comb begin
        st_d = st_q;
        if (cs_start) begin
            st_d.shreg = load_val;
            st_d.cnt   = '0;
            st_d.miso  = load_val[WIDTH-1];
        end else if (cs_active) begin
            if (sclk_ev.rise) begin
                st_d.shreg = {st_q.shreg[WIDTH-2:0], mosi_bit};
                if (st_q.cnt != CNT_SAT) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            if (sclk_ev.fall) begin
                st_d.miso = st_q.shreg[WIDTH-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word     = st_q.shreg;
    assign count    = st_q.cnt;
    assign miso_bit = st_q.miso;

    // R9: data-out only moves on a falling serial edge or on select activation
    assert_miso_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!sclk_ev.fall && !cs_ev.fall) |=> $stable(st_q.miso));

    // R8: no serial activity is absorbed while select is inactive
    assert_idle_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        cs_ev.level |=> ($stable(st_q.shreg) && $stable(st_q.cnt)));
endmodule

// File: rtl/spx_outreg.sv
module spx_outreg #(
    parameter int WIDTH = 8,
    parameter int CW    = $clog2(WIDTH + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_end,
    input  logic [CW-1:0]    count,
    input  logic [WIDTH-1:0] word,
    output logic [WIDTH-1:0] pins
);
    localparam logic [CW-1:0] CNT_FULL = CW'(WIDTH);

    typedef struct packed {
        logic [WIDTH-1:0] pins;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cs_end && (count == CNT_FULL)) begin
            st_d.pins = word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pins = st_q.pins;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (st_q.pins == '0));

    assert_hold_between_R3: assert property (@(posedge clk) disable iff (rst)
        !cs_end |=> $stable(st_q.pins));

    assert_full_load_R2: assert property (@(posedge clk) disable iff (rst)
        (cs_end && count == CNT_FULL) |=> (st_q.pins == $past(word)));

    // covers R5 as well: any count other than WIDTH is discarded
    assert_bad_len_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (cs_end && count != CNT_FULL) |=> $stable(st_q.pins));
endmodule

// File: rtl/spi_pin_expander.sv
module spi_pin_expander #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             spi_sclk,
    input  logic             spi_cs_n,
    input  logic             spi_mosi,
    output logic             spi_miso,
    output logic             spi_miso_oe,
    output logic [WIDTH-1:0] pins
);
    localparam int CW       = $clog2(WIDTH + 2);
    localparam int N_IN     = 3;
    localparam int IDX_MOSI = 0;
    localparam int IDX_SCLK = 1;
    localparam int IDX_CS   = 2;

    logic [N_IN-1:0]    raw_in;
    spx_pkg::spx_edge_t in_ev [N_IN];
    logic [WIDTH-1:0]   word;
    logic [CW-1:0]      count;
    logic               miso_bit;
    logic               cs_active;

    assign raw_in = {spi_cs_n, spi_sclk, spi_mosi};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        spx_sync_edge #(
            .STAGES (SYNC_STAGES),
            .IDLE   ((g == IDX_CS) ? 1'b1 : 1'b0)
        ) u_sync (
            .clk (clk),
            .rst (rst),
            .din (raw_in[g]),
            .ev  (in_ev[g])
        );
    end

    spx_shifter #(.WIDTH(WIDTH), .CW(CW)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .sclk_ev  (in_ev[IDX_SCLK]),
        .cs_ev    (in_ev[IDX_CS]),
        .mosi_bit (in_ev[IDX_MOSI].level),
        .load_val (pins),
        .word     (word),
        .count    (count),
        .miso_bit (miso_bit)
    );

    spx_outreg #(.WIDTH(WIDTH), .CW(CW)) u_out (
        .clk    (clk),
        .rst    (rst),
        .cs_end (in_ev[IDX_CS].rise),
        .count  (count),
        .word   (word),
        .pins   (pins)
    );

    assign cs_active   = ~in_ev[IDX_CS].level;
    assign spi_miso    = cs_active & miso_bit;
    assign spi_miso_oe = cs_active;
endmodule

// File: tb/spi_pin_expander_bench.sv
module spi_pin_expander_bench;
    localparam int W    = 8;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, miso_oe;
    logic [W-1:0] pins;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [W-1:0] exp_pins = '0;

    always #5 clk = ~clk;

    spi_pin_expander #(.WIDTH(W)) u_spi_pin_expander (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe), .pins(pins)
    );

    // {bit count, data word}
    localparam int NV = 7;
    localparam logic [11:0] VEC [NV] = '{
        {4'd8, 8'hA5}, {4'd8, 8'h3C}, {4'd7, 8'hFF}, {4'd8, 8'h00},
        {4'd9, 8'h81}, {4'd8, 8'hFF}, {4'd8, 8'h81}
    };

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [W-1:0] data, input int nbits);
        logic [2*W-1:0] stream;
        stream = {exp_pins, data};
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            mosi = data[(W-1 - i + 2*W) % W];
            wait_clk(HALF/2);
            check(miso == stream[2*W-1-i], "R6 readback bit", miso, stream[2*W-1-i]);
            check(miso_oe == 1'b1, "R7 oe while selected", miso_oe, 1);
            if (i == W/2)
                check(pins == exp_pins, "R3 pins steady mid-transfer", pins, exp_pins);
            wait_clk(HALF/2);
            sclk = 1'b1;
            wait_clk(HALF - 2);
            check(miso == stream[2*W-1-i], "R9 miso held after rise", miso, stream[2*W-1-i]);
            wait_clk(2);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(HALF);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        wait_clk(4);
        check(pins == '0, "R1 pins in reset", pins, 0);
        check(miso == 1'b0, "R1 miso in reset", miso, 0);
        check(miso_oe == 1'b0, "R1 oe in reset", miso_oe, 0);
        rst = 1'b0;
        wait_clk(4);

        for (int v = 0; v < NV; v++) begin
            int          nb;
            logic [W-1:0] dw;
            nb = int'(VEC[v][11:8]);
            dw = VEC[v][7:0];
            xfer(dw, nb);
            if (nb == W) begin
                exp_pins = dw;
                check(pins == exp_pins, "R2 word loaded", pins, exp_pins);
            end else if (nb < W) begin
                check(pins == exp_pins, "R4 short transfer discarded", pins, exp_pins);
            end else begin
                check(pins == exp_pins, "R5 long transfer discarded", pins, exp_pins);
            end
            check(miso == 1'b0 && miso_oe == 1'b0, "R7 idle miso/oe",
                  {miso, miso_oe}, 0);
        end

        // R8: serial clocks with select inactive
        for (int k = 0; k < 5; k++) begin
            mosi = k[0];
            sclk = 1'b1; wait_clk(HALF);
            sclk = 1'b0; wait_clk(HALF);
            check(miso == 1'b0, "R8 miso quiet while deselected", miso, 0);
        end
        check(pins == exp_pins, "R8 pins unaffected", pins, exp_pins);
        xfer(8'h5A, W);
        exp_pins = 8'h5A;
        check(pins == exp_pins, "R8 next transfer normal", pins, exp_pins);

        // R1: reset after activity
        rst = 1'b1;
        wait_clk(3);
        exp_pins = '0;
        check(pins == '0, "R1 reset clears pins", pins, 0);
        rst = 1'b0;
        wait_clk(4);
        xfer(8'hC3, W);
        exp_pins = 8'hC3;
        check(pins == exp_pins, "R2 load after reset", pins, exp_pins);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule